// File: doc/BRIEF.md
# ADC Conversion Flag and Trigger Controller

This block sits next to a 16-slot analog-to-digital conversion sequencer. It holds one conversion-complete flag for each result slot and a sequence-complete flag. From these it raises two interrupt requests. A slot that has automatic compare turned on only gets its flag when the compare succeeds. Software clears flags in one of two ways. In normal mode it writes ones to the flag register. In fast-clear mode it simply accesses the result register of that slot. For a slot with compare off, a read clears the flag. For a slot with compare on, a write clears it.

The block also conditions a raw external start-of-conversion line. It synchronizes the line, then detects an edge or a level, in a polarity that software selects. The result is a start signal for the sequencer.

Register access uses a select code `bus_kind`: 0 is control, 1 is the flag register, 2 is status, and 3 is a result register whose slot is given by `bus_slot`. The control register bits are:

| Bit | Function |
|-----|----------|
| 0 | fast-clear mode |
| 1 | trigger enable |
| 2 | trigger polarity |
| 3 | trigger level/edge select |
| 4 | sequence interrupt enable |
| 5 | compare interrupt enable |

Top module: `adc_flag_ctrl`

## Requirements
- R1: After reset, all flags, the sequence-complete flag, both interrupt requests, the trigger output and all control bits are 0.
- R2: A `conv_done[n]` strobe on a slot whose `cmp_en[n]` is 0 sets `flags[n]`, visible one cycle after the strobe.
- R3: For a slot with `cmp_en[n]`=1, `conv_done[n]` sets `flags[n]` only if `cmp_match[n]`=1 in that same cycle.
- R4: With control bit 0 (fast-clear) at 0, a write with `bus_kind`=1 clears every flag whose `bus_wdata` bit is 1. Accesses with `bus_kind`=3 leave the flags unchanged.
- R5: With fast-clear at 1 and `cmp_en[n]`=0, a read with `bus_kind`=3 and `bus_slot`=n clears `flags[n]`. A write to that same result register leaves the flag unchanged.
- R6: With fast-clear at 1 and `cmp_en[n]`=1, a write with `bus_kind`=3 and `bus_slot`=n clears `flags[n]`. A read of that register leaves the flag unchanged.
- R7: When a set and a clear reach the same flag, or the sequence-complete flag, in the same cycle, the flag ends up at 1.
- R8: `seq_done` sets the sequence-complete flag. A write with `bus_kind`=2 and `bus_wdata[0]`=1 clears it. `seq_irq` is 1 exactly when this flag is 1 and control bit 4 is 1.
- R9: `cmp_irq` is 1 exactly when control bit 5 is 1 and some `flags[n]` with `cmp_en[n]`=1 is set.
- R10: The trigger line passes through two synchronizer flops. The sensitivity is chosen by {bit 3, bit 2}: 00 is falling edge, 01 is rising edge, 10 is low level, 11 is high level. In edge modes, `trig_start` is high for exactly one cycle per edge, two cycles after the raw line changes.
- R11: In level modes, `trig_start` stays high for as long as the synchronized line matches the polarity bit.
- R12: With control bit 1 (trigger enable) at 0, `trig_start` stays 0 whatever the raw line does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 16 | Per-slot conversion-done strobes |
| cmp_en | input | 16 | Per-slot compare-enable |
| cmp_match | input | 16 | Per-slot compare-success |
| seq_done | input | 1 | Sequence-done strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_kind | input | 2 | Register select (0 control, 1 flags, 2 status, 3 result) |
| bus_slot | input | 4 | Result slot index |
| bus_wdata | input | 16 | Write data |
| trig_raw | input | 1 | Raw external trigger |
| flags | output | 16 | Conversion-complete flags |
| seq_irq | output | 1 | Sequence-complete interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |
| trig_start | output | 1 | Conditioned start-of-conversion |

## Verification
Two events can hit the same flag in one cycle: a conversion completing and a software clear. The clear can be a result-register read in fast-clear mode or a write-one-to-clear in normal mode. The bench drives `conv_done[2]` in the same cycle as each kind of clear. It does the same with `seq_done` and a status write-one-to-clear. It expects the flag to read 1 on the next cycle. The bench also checks that the flag still clears when the clear arrives without a competing set.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_FLAGS  = 2'd1,
    REG_STAT   = 2'd2,
    REG_RESULT = 2'd3
  } reg_kind_e;

  // control register layout, bit 5 down to bit 0
  typedef struct packed {
    logic cmp_ie;
    logic seq_ie;
    logic trig_lvl;
    logic trig_pol;
    logic trig_en;
    logic fast_clr;
  } ctrl_t;

  localparam int CTRL_W = 6;

endpackage

// File: rtl/adc_flag_bank.sv
module adc_flag_bank
  import adc_flag_pkg::*;
#(
  parameter int N_SLOTS = 16,
  parameter int SLOT_W  = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] conv_done,
  input  logic [N_SLOTS-1:0] cmp_en,
  input  logic [N_SLOTS-1:0] cmp_match,
  input  logic               fast_clr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  reg_kind_e          bus_kind,
  input  logic [SLOT_W-1:0]  bus_slot,
  input  logic [N_SLOTS-1:0] bus_wdata,
  output logic [N_SLOTS-1:0] flags
);

  logic [N_SLOTS-1:0] flags_q;
  logic               w1c_hit;
  logic               res_rd;
  logic               res_wr;

  always_comb begin
    w1c_hit = bus_wr && (bus_kind == REG_FLAGS) && !fast_clr;
    res_rd  = bus_rd && (bus_kind == REG_RESULT) && fast_clr;
    res_wr  = bus_wr && (bus_kind == REG_RESULT) && fast_clr;
  end

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic set_i;
    logic clr_i;
    logic slot_sel;
    logic nxt_i;

    always_comb begin
      slot_sel = (bus_slot == SLOT_W'(i));
      set_i    = conv_done[i] && (!cmp_en[i] || cmp_match[i]);
      clr_i    = (w1c_hit && bus_wdata[i])
               || (slot_sel && res_rd && !cmp_en[i])
               || (slot_sel && res_wr &&  cmp_en[i]);
      // a set beats a clear in the same cycle
      nxt_i    = set_i ? 1'b1 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flags_q[i] <= 1'b0;
      else if (set_i || clr_i) flags_q[i] <= nxt_i;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done[i] && (!cmp_en[i] || cmp_match[i])) |=> flags_q[i]);

    // R3
    cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done[i] && cmp_en[i] && !cmp_match[i] && !flags_q[i]) |=> !flags_q[i]);

    // R4
    normal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast_clr && flags_q[i] && !(bus_wr && bus_kind == REG_FLAGS && bus_wdata[i]))
      |=> flags_q[i]);
  end

  assign flags = flags_q;

endmodule

// File: rtl/adc_irq_gen.sv
module adc_irq_gen #(
  parameter int N_SLOTS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seq_done,
  input  logic               stat_w1c,
  input  logic               seq_ie,
  input  logic               cmp_ie,
  input  logic [N_SLOTS-1:0] flags,
  input  logic [N_SLOTS-1:0] cmp_en,
  output logic               seq_irq,
  output logic               cmp_irq
);

  logic seq_q;
  logic seq_nxt;
  logic seq_upd;

  always_comb begin
    seq_upd = seq_done || stat_w1c;
    seq_nxt = seq_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seq_q <= 1'b0;
    else if (seq_upd) seq_q <= seq_nxt;
  end

  always_comb begin
    seq_irq = seq_ie && seq_q;
    cmp_irq = cmp_ie && (|(flags & cmp_en));
  end

  // R8
  seq_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (seq_irq == seq_ie));

endmodule

// File: rtl/adc_trig_cond.sv
module adc_trig_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_raw,
  input  logic trig_en,
  input  logic trig_lvl,
  input  logic trig_pol,
  output logic trig_start
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_nxt;
  logic                   prev_q;
  logic                   s_now;
  logic                   edge_hit;
  logic                   lvl_hit;

  always_comb begin
    sync_nxt = {sync_q[SYNC_STAGES-2:0], trig_raw};
    s_now    = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_nxt;
      prev_q <= s_now;
    end
  end

  always_comb begin
    edge_hit   = trig_pol ? (s_now && !prev_q) : (!s_now && prev_q);
    lvl_hit    = (s_now == trig_pol);
    trig_start = trig_en && (trig_lvl ? lvl_hit : edge_hit);
  end

  // R10
  edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_start && !trig_lvl) |=> (!trig_start || trig_lvl || !$stable(trig_pol)));

endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl
  import adc_flag_pkg::*;
#(
  parameter int N_SLOTS     = 16,
  parameter int SLOT_W      = $clog2(N_SLOTS),
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = (N_SLOTS > CTRL_W) ? N_SLOTS : CTRL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] conv_done,
  input  logic [N_SLOTS-1:0] cmp_en,
  input  logic [N_SLOTS-1:0] cmp_match,
  input  logic               seq_done,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [1:0]         bus_kind,
  input  logic [SLOT_W-1:0]  bus_slot,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               trig_raw,
  output logic [N_SLOTS-1:0] flags,
  output logic               seq_irq,
  output logic               cmp_irq,
  output logic               trig_start
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  reg_kind_e  kind;
  ctrl_t      ctrl_q;
  ctrl_t      ctrl_nxt;
  logic       ctrl_we;
  logic       stat_w1c;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    kind     = reg_kind_e'(bus_kind);
    ctrl_we  = bus_wr && (kind == REG_CTRL);
    ctrl_nxt = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    stat_w1c = bus_wr && (kind == REG_STAT) && bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_nxt;
  end

  adc_flag_bank #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .conv_done (conv_done),
    .cmp_en    (cmp_en),
    .cmp_match (cmp_match),
    .fast_clr  (ctrl_q.fast_clr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_kind  (kind),
    .bus_slot  (bus_slot),
    .bus_wdata (bus_wdata[N_SLOTS-1:0]),
    .flags     (flags)
  );

  adc_irq_gen #(.N_SLOTS(N_SLOTS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .seq_done (seq_done),
    .stat_w1c (stat_w1c),
    .seq_ie   (ctrl_q.seq_ie),
    .cmp_ie   (ctrl_q.cmp_ie),
    .flags    (flags),
    .cmp_en   (cmp_en),
    .seq_irq  (seq_irq),
    .cmp_irq  (cmp_irq)
  );

  adc_trig_cond #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .trig_raw   (trig_raw),
    .trig_en    (ctrl_q.trig_en),
    .trig_lvl   (ctrl_q.trig_lvl),
    .trig_pol   (ctrl_q.trig_pol),
    .trig_start (trig_start)
  );

  // R9
  cmp_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmp_irq |-> (|flags));

endmodule

// File: tb/tb_adc_flag_ctrl.sv
module tb_adc_flag_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] conv_done = '0, cmp_en = '0, cmp_match = '0;
  logic        seq_done = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_kind = '0;
  logic [3:0]  bus_slot = '0;
  logic [15:0] bus_wdata = '0;
  logic        trig_raw = 1'b0;
  logic [15:0] flags;
  logic        seq_irq, cmp_irq, trig_start;

  typedef struct {string req; int sel; logic [15:0] val;} item_t;
  item_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_flag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .cmp_en(cmp_en),
    .cmp_match(cmp_match), .seq_done(seq_done), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_kind(bus_kind), .bus_slot(bus_slot), .bus_wdata(bus_wdata),
    .trig_raw(trig_raw), .flags(flags), .seq_irq(seq_irq), .cmp_irq(cmp_irq),
    .trig_start(trig_start)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = q.pop_front();
      case (it.sel)
        0: got = flags;
        1: got = {15'd0, seq_irq};
        2: got = {15'd0, cmp_irq};
        default: got = {15'd0, trig_start};
      endcase
      total++;
      if (got !== it.val) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.val);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic expect_v(string r, int sel, logic [15:0] v);
    q.push_back('{r, sel, v});
  endtask

  task automatic wr(logic [1:0] k, logic [3:0] s, logic [15:0] d);
    bus_wr = 1'b1; bus_kind = k; bus_slot = s; bus_wdata = d;
    cyc();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] k, logic [3:0] s);
    bus_rd = 1'b1; bus_kind = k; bus_slot = s;
    cyc();
    bus_rd = 1'b0;
  endtask

  task automatic done_pulse(int n, logic m);
    conv_done[n] = 1'b1; cmp_match[n] = m;
    cyc();
    conv_done[n] = 1'b0; cmp_match[n] = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    // R1 reset state
    expect_v("R1", 0, 16'h0000); expect_v("R1", 1, 0);
    expect_v("R1", 2, 0);        expect_v("R1", 3, 0);
    cyc();

    // R2 plain slot sets
    done_pulse(3, 1'b0);
    expect_v("R2", 0, 16'h0008);
    // R4 normal mode: result access does not clear, W1C does
    rd(2'd3, 4'd3);
    expect_v("R4", 0, 16'h0008);
    wr(2'd3, 4'd3, 16'hFFFF);
    expect_v("R4", 0, 16'h0008);
    wr(2'd1, 4'd0, 16'h0008);
    expect_v("R4", 0, 16'h0000);

    // R3 compare slot needs a match
    cmp_en[5] = 1'b1;
    done_pulse(5, 1'b0);
    expect_v("R3", 0, 16'h0000);
    done_pulse(5, 1'b1);
    expect_v("R3", 0, 16'h0020);
    // R9 compare interrupt
    expect_v("R9", 2, 0);
    wr(2'd0, 4'd0, 16'h0020);
    expect_v("R9", 2, 1);

    // R6 fast clear on compare slot
    wr(2'd0, 4'd0, 16'h0021);
    rd(2'd3, 4'd5);
    expect_v("R6", 0, 16'h0020);
    wr(2'd3, 4'd5, 16'h1234);
    expect_v("R6", 0, 16'h0000);
    expect_v("R9", 2, 0);

    // R5 fast clear on plain slot
    done_pulse(2, 1'b0);
    expect_v("R5", 0, 16'h0004);
    expect_v("R9", 2, 0);
    wr(2'd3, 4'd2, 16'h0000);
    expect_v("R5", 0, 16'h0004);
    rd(2'd3, 4'd2);
    expect_v("R5", 0, 16'h0000);

    // R7 set beats a fast-clear read
    conv_done[2] = 1'b1;
    rd(2'd3, 4'd2);
    conv_done[2] = 1'b0;
    expect_v("R7", 0, 16'h0004);
    // R7 set beats a W1C in normal mode
    wr(2'd0, 4'd0, 16'h0000);
    conv_done[2] = 1'b1;
    wr(2'd1, 4'd0, 16'h0004);
    conv_done[2] = 1'b0;
    expect_v("R7", 0, 16'h0004);
    wr(2'd1, 4'd0, 16'h0004);
    expect_v("R4", 0, 16'h0000);

    // R8 sequence flag and interrupt
    seq_done = 1'b1; cyc(); seq_done = 1'b0;
    expect_v("R8", 1, 0);
    wr(2'd0, 4'd0, 16'h0010);
    expect_v("R8", 1, 1);
    wr(2'd2, 4'd0, 16'h0001);
    expect_v("R8", 1, 0);
    seq_done = 1'b1;
    wr(2'd2, 4'd0, 16'h0001);
    seq_done = 1'b0;
    expect_v("R7", 1, 1);
    wr(2'd2, 4'd0, 16'h0001);
    expect_v("R8", 1, 0);

    // R10 rising edge
    wr(2'd0, 4'd0, 16'h0006);
    cyc(); cyc();
    trig_raw = 1'b1;
    cyc(); expect_v("R10", 3, 0);
    cyc(); expect_v("R10", 3, 1);
    cyc(); expect_v("R10", 3, 0);
    cyc(); expect_v("R10", 3, 0);
    // R10 falling edge
    wr(2'd0, 4'd0, 16'h0002);
    expect_v("R10", 3, 0);
    trig_raw = 1'b0;
    cyc(); cyc(); expect_v("R10", 3, 1);
    cyc(); expect_v("R10", 3, 0);
    trig_raw = 1'b1;
    cyc(); cyc(); expect_v("R10", 3, 0);
    cyc();

    // R11 high level, then low level
    wr(2'd0, 4'd0, 16'h000E);
    expect_v("R11", 3, 1);
    cyc(); expect_v("R11", 3, 1);
    cyc(); expect_v("R11", 3, 1);
    wr(2'd0, 4'd0, 16'h000A);
    expect_v("R11", 3, 0);
    trig_raw = 1'b0;
    cyc(); expect_v("R11", 3, 0);
    cyc(); expect_v("R11", 3, 1);
    cyc(); expect_v("R11", 3, 1);

    // R12 disabled trigger is ignored
    wr(2'd0, 4'd0, 16'h0004);
    trig_raw = 1'b1;
    for (int k = 0; k < 4; k++) begin cyc(); expect_v("R12", 3, 0); end
    wr(2'd0, 4'd0, 16'h000C);
    expect_v("R12", 3, 0);
    cyc(); expect_v("R12", 3, 0);

    cyc(); cyc();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule